// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a processor request bus and the command/address side of a host-to-PCI bridge. Processor accesses that fall inside the PCI I/O window are turned into PCI requests. A full-width access to the configuration-address slot reads or writes an internal setup register. An access to the configuration-data slot becomes a type-0 configuration cycle when the stored setup is valid and the access width is legal. The outgoing address of that cycle carries a one-hot device select line in its upper bits. In every other case the access is forwarded unchanged as an ordinary I/O transfer.

Every result appears one clock after the request. A result is a PCI request pulse, or a read response for the setup register. Arbitration, PCI electrical timing and the data phase belong to other blocks.

Top module: `pci_cfg_xlate`

## Requirements
- R1: After reset, `pci_req_valid` and `rsp_valid` are 0 and the setup register holds 0.
- R2: A request with all four byte enables set at window base + 0xCF8 issues no PCI request. A write stores the fields enable (bit 31), bus (23:16), device (15:11), function (10:8) and register (7:2). A read returns those fields on `rsp_rdata`, with `rsp_valid` high one cycle after the request, and all other bits read as 0.
- R3: Any access at window base + 0xCF8 whose byte enables are not all set is forwarded as an I/O cycle to address 0xCF8 and leaves the setup register unchanged.
- R4: An access at window base + 0xCFC with a legal width and a valid setup issues a configuration cycle one cycle later. The command is 0xA for a read and 0xB for a write.
- R5: The configuration-cycle address has bits 1:0 = 00, bits 7:2 = register, bits 10:8 = function, and exactly one bit set in 31:11, at bit 11 + device.
- R6: The setup is valid only when enable = 1, bus = 0 and device < 20. Otherwise a data-slot access is forwarded as an I/O cycle to address 0xCFC.
- R7: Legal byte-enable patterns are 0001, 0010, 0100, 1000, 0011, 1100 and 1111. Any other pattern at the data slot gives an I/O cycle.
- R8: Any other in-window access issues an I/O cycle one cycle later. The command is 0x2 for a read and 0x3 for a write, and the address is the offset from the window base.
- R9: Requests outside the window (upper 16 address bits differ from 0x8000) produce no PCI request and no response, and leave the setup register unchanged.
- R10: Byte enables and write data pass unchanged onto `pci_be` and `pci_wdata` for both configuration and I/O cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Processor byte address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Setup-register read data valid |
| rsp_rdata | output | 32 | Setup-register read data |
| pci_req_valid | output | 1 | PCI request pulse |
| pci_cmd | output | 4 | PCI bus command |
| pci_addr | output | 32 | PCI address phase value |
| pci_be | output | 4 | PCI byte enables |
| pci_wdata | output | 32 | Write data for the PCI cycle |

## Verification
The assertions assume that `req_valid` and the other request fields are known values, sampled at the rising edge while reset is released. They assume that each request is a single-cycle pulse with no back-pressure, so each one maps to exactly one result a cycle later. The bench drives every request at the falling edge for one cycle only and returns `req_valid` to 0 between requests. It reads the setup register back only through a legal full-width access, so every request it issues stays inside these assumptions.

// File: rtl/pci_xlate_pkg.sv
package pci_xlate_pkg;

    localparam logic [3:0] CMD_IO_RD  = 4'h2;
    localparam logic [3:0] CMD_IO_WR  = 4'h3;
    localparam logic [3:0] CMD_CFG_RD = 4'hA;
    localparam logic [3:0] CMD_CFG_WR = 4'hB;

    localparam logic [11:0] SETUP_OFF = 12'hCF8;
    localparam logic [11:0] DATA_OFF  = 12'hCFC;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] regn;
    } cfg_setup_t;

    function automatic cfg_setup_t setup_from_word(logic [31:0] w);
        cfg_setup_t s;
        s.en   = w[31];
        s.bus  = w[23:16];
        s.dev  = w[15:11];
        s.fn   = w[10:8];
        s.regn = w[7:2];
        return s;
    endfunction

    function automatic logic [31:0] setup_to_word(cfg_setup_t s);
        return {s.en, 7'b0, s.bus, s.dev, s.fn, s.regn, 2'b00};
    endfunction

endpackage

// File: rtl/pci_be_width_check.sv
module pci_be_width_check (
    input  logic [3:0] be,
    output logic       legal
);
    logic single_byte;
    logic half_word;
    logic full_word;

    always_comb begin
        single_byte = $onehot(be);
        half_word   = (be == 4'b0011) || (be == 4'b1100);
        full_word   = &be;
        legal       = single_byte || half_word || full_word;
    end
endmodule

// File: rtl/pci_win_decode.sv
module pci_win_decode #(
    parameter logic [31:0] IO_BASE  = 32'h8000_0000,
    parameter int          WIN_BITS = 16
) (
    input  logic [31:0]         addr,
    output logic                in_win,
    output logic [WIN_BITS-1:0] offset,
    output logic                setup_hit,
    output logic                data_hit
);
    import pci_xlate_pkg::*;

    localparam logic [WIN_BITS-3:0] SETUP_WORD = WIN_BITS'(SETUP_OFF) >> 2;
    localparam logic [WIN_BITS-3:0] DATA_WORD  = WIN_BITS'(DATA_OFF) >> 2;

    always_comb begin
        in_win    = (addr[31:WIN_BITS] == IO_BASE[31:WIN_BITS]);
        offset    = addr[WIN_BITS-1:0];
        setup_hit = in_win && (offset[WIN_BITS-1:2] == SETUP_WORD);
        data_hit  = in_win && (offset[WIN_BITS-1:2] == DATA_WORD);
    end
endmodule

// File: rtl/pci_cfg_addr_gen.sv
module pci_cfg_addr_gen #(
    parameter int IDSEL_LSB   = 11,
    parameter int IDSEL_LINES = 20
) (
    input  pci_xlate_pkg::cfg_setup_t setup,
    output logic                      valid,
    output logic [31:0]               addr
);
    logic [IDSEL_LINES-1:0] idsel;

    for (genvar i = 0; i < IDSEL_LINES; i++) begin : g_idsel
        assign idsel[i] = (32'(setup.dev) == i);
    end

    always_comb begin
        valid = setup.en && (setup.bus == 8'd0) && (32'(setup.dev) < IDSEL_LINES);
        addr  = '0;
        addr[IDSEL_LSB +: IDSEL_LINES] = idsel;
        addr[10:8] = setup.fn;
        addr[7:2]  = setup.regn;
        addr[1:0]  = 2'b00;
    end
endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate #(
    parameter logic [31:0] IO_BASE     = 32'h8000_0000,
    parameter int          WIN_BITS    = 16,
    parameter int          IDSEL_LSB   = 11,
    parameter int          IDSEL_LINES = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [3:0]  req_be,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        pci_req_valid,
    output logic [3:0]  pci_cmd,
    output logic [31:0] pci_addr,
    output logic [3:0]  pci_be,
    output logic [31:0] pci_wdata
);
    import pci_xlate_pkg::*;

    localparam int PAD_BITS = 32 - WIN_BITS;

    typedef struct packed {
        cfg_setup_t  setup;
        logic        pci_vld;
        logic [3:0]  cmd;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic        rsp_vld;
        logic [31:0] rdata;
    } xlate_state_t;

    xlate_state_t st_q, st_d;

    logic                in_win, setup_hit, data_hit;
    logic [WIN_BITS-1:0] win_off;
    logic                be_ok;
    logic                setup_ok;
    logic [31:0]         cfg_addr;

    pci_win_decode #(.IO_BASE(IO_BASE), .WIN_BITS(WIN_BITS)) u_dec (
        .addr(req_addr), .in_win(in_win), .offset(win_off),
        .setup_hit(setup_hit), .data_hit(data_hit)
    );

    pci_be_width_check u_width (.be(req_be), .legal(be_ok));

    pci_cfg_addr_gen #(.IDSEL_LSB(IDSEL_LSB), .IDSEL_LINES(IDSEL_LINES)) u_gen (
        .setup(st_q.setup), .valid(setup_ok), .addr(cfg_addr)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pci_vld = 1'b0;
        st_d.rsp_vld = 1'b0;
        if (req_valid && in_win) begin
            if (setup_hit && (&req_be)) begin
                if (req_write) begin
                    st_d.setup = setup_from_word(req_wdata);
                end else begin
                    st_d.rsp_vld = 1'b1;
                    st_d.rdata   = setup_to_word(st_q.setup);
                end
            end else begin
                st_d.pci_vld = 1'b1;
                st_d.be      = req_be;
                st_d.wdata   = req_wdata;
                if (data_hit && be_ok && setup_ok) begin
                    st_d.cmd  = req_write ? CMD_CFG_WR : CMD_CFG_RD;
                    st_d.addr = cfg_addr;
                end else begin
                    st_d.cmd  = req_write ? CMD_IO_WR : CMD_IO_RD;
                    st_d.addr = {{PAD_BITS{1'b0}}, win_off};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid     = st_q.rsp_vld;
    assign rsp_rdata     = st_q.rdata;
    assign pci_req_valid = st_q.pci_vld;
    assign pci_cmd       = st_q.cmd;
    assign pci_addr      = st_q.addr;
    assign pci_be        = st_q.be;
    assign pci_wdata     = st_q.wdata;

    assert_cfg_idsel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_req_valid && pci_cmd[3]) |->
            ($countones(pci_addr[31:IDSEL_LSB]) == 1 && pci_addr[1:0] == 2'b00));

    assert_setup_slot_no_pci_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && setup_hit && (&req_be)) |=> !pci_req_valid);

    assert_bad_width_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_win && !be_ok) |=> (pci_req_valid && !pci_cmd[3]));

    assert_invalid_setup_io_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && data_hit && !setup_ok) |=> (pci_req_valid && !pci_cmd[3]));

    assert_outside_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_win) |=> (!pci_req_valid && !rsp_valid));

    assert_one_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_win) |=> (pci_req_valid != rsp_valid) || (!pci_req_valid && $past(req_write)));

    assert_cmd_direction_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_win) |=> (!pci_req_valid || (pci_cmd[0] == $past(req_write))));
endmodule

// File: tb/pci_cfg_xlate_tb_top.sv
module pci_cfg_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [31:0] req_addr, req_wdata;
    logic [3:0]  req_be;
    logic        rsp_valid, pci_req_valid;
    logic [31:0] rsp_rdata, pci_addr, pci_wdata;
    logic [3:0]  pci_cmd, pci_be;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pci_cfg_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pci_req_valid(pci_req_valid),
        .pci_cmd(pci_cmd), .pci_addr(pci_addr), .pci_be(pci_be), .pci_wdata(pci_wdata)
    );

    localparam logic [31:0] SETUP_A = 32'h8000_0CF8;
    localparam logic [31:0] DATA_A  = 32'h8000_0CFC;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // One-cycle request at the falling edge; outputs sampled at the next falling edge.
    task automatic issue(logic wr, logic [31:0] a, logic [3:0] be, logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [31:0] cfg_word(logic en, logic [7:0] bus, int dev, int fn, int rg);
        return {en, 7'b0, bus, 5'(dev), 3'(fn), 6'(rg), 2'b00};
    endfunction

    function automatic logic [31:0] cfg_addr_exp(int dev, int fn, int rg);
        return (32'h1 << (11 + dev)) | (32'(fn) << 8) | (32'(rg) << 2);
    endfunction

    task automatic expect_pci(string tag, logic [3:0] cmd, logic [31:0] a, logic [3:0] be, logic [31:0] wd);
        chk({tag, " valid"}, {31'b0, pci_req_valid}, 32'd1);
        chk({tag, " cmd"}, {28'b0, pci_cmd}, {28'b0, cmd});
        chk({tag, " addr"}, pci_addr, a);
        chk({tag, " be"}, {28'b0, pci_be}, {28'b0, be});
        chk({tag, " wdata"}, pci_wdata, wd);
        chk({tag, " no rsp"}, {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic read_setup(string tag, logic [31:0] exp);
        issue(1'b0, SETUP_A, 4'hF, 32'h0);
        chk({tag, " rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
        chk({tag, " no pci"}, {31'b0, pci_req_valid}, 32'd0);
        chk({tag, " rdata"}, rsp_rdata, exp);
    endtask

    task automatic t_reset;
        chk("R1 pci_req_valid in reset", {31'b0, pci_req_valid}, 32'd0);
        chk("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        read_setup("R1 setup after reset", 32'h0);
    endtask

    task automatic t_setup_slot;
        issue(1'b1, SETUP_A, 4'hF, 32'hFFFF_FFFF);
        chk("R2 write no pci", {31'b0, pci_req_valid}, 32'd0);
        read_setup("R2 readback", 32'h80FF_FFFC);
    endtask

    task automatic t_setup_narrow;
        issue(1'b1, SETUP_A, 4'b0011, 32'h0000_0000);
        expect_pci("R3 narrow write", 4'h3, 32'h0000_0CF8, 4'b0011, 32'h0);
        issue(1'b0, SETUP_A, 4'b1000, 32'h0);
        expect_pci("R3 narrow read", 4'h2, 32'h0000_0CF8, 4'b1000, 32'h0);
        read_setup("R3 setup unchanged", 32'h80FF_FFFC);
    endtask

    task automatic t_cfg_cycles;
        issue(1'b1, SETUP_A, 4'hF, cfg_word(1'b1, 8'd0, 3, 5, 16));
        issue(1'b0, DATA_A, 4'hF, 32'h0);
        expect_pci("R4 R5 cfg read dev3", 4'hA, cfg_addr_exp(3, 5, 16), 4'hF, 32'h0);
        issue(1'b1, DATA_A, 4'b1100, 32'h1234_5678);
        expect_pci("R4 R10 cfg write", 4'hB, 32'h0000_4540, 4'b1100, 32'h1234_5678);
        issue(1'b1, SETUP_A, 4'hF, cfg_word(1'b1, 8'd0, 19, 0, 0));
        issue(1'b0, DATA_A, 4'hF, 32'h0);
        expect_pci("R5 dev19 top line", 4'hA, 32'h4000_0000, 4'hF, 32'h0);
        issue(1'b1, SETUP_A, 4'hF, cfg_word(1'b1, 8'd0, 0, 7, 63));
        issue(1'b0, DATA_A, 4'b0001, 32'h0);
        expect_pci("R5 dev0", 4'hA, 32'h0000_0FFC, 4'b0001, 32'h0);
    endtask

    task automatic t_invalid_setup;
        issue(1'b1, SETUP_A, 4'hF, cfg_word(1'b1, 8'd0, 20, 1, 1));
        issue(1'b0, DATA_A, 4'hF, 32'h0);
        expect_pci("R6 dev20", 4'h2, 32'h0000_0CFC, 4'hF, 32'h0);
        issue(1'b1, SETUP_A, 4'hF, cfg_word(1'b0, 8'd0, 2, 0, 0));
        issue(1'b1, DATA_A, 4'hF, 32'hCAFE_0001);
        expect_pci("R6 disabled", 4'h3, 32'h0000_0CFC, 4'hF, 32'hCAFE_0001);
        issue(1'b1, SETUP_A, 4'hF, cfg_word(1'b1, 8'd1, 2, 0, 0));
        issue(1'b0, DATA_A, 4'hF, 32'h0);
        expect_pci("R6 bus1", 4'h2, 32'h0000_0CFC, 4'hF, 32'h0);
    endtask

    task automatic t_widths;
        issue(1'b1, SETUP_A, 4'hF, cfg_word(1'b1, 8'd0, 4, 0, 1));
        issue(1'b0, DATA_A, 4'b0110, 32'h0);
        expect_pci("R7 be0110", 4'h2, 32'h0000_0CFC, 4'b0110, 32'h0);
        issue(1'b0, DATA_A, 4'b0111, 32'h0);
        expect_pci("R7 be0111", 4'h2, 32'h0000_0CFC, 4'b0111, 32'h0);
        issue(1'b1, DATA_A, 4'b0000, 32'h5);
        expect_pci("R7 be0000", 4'h3, 32'h0000_0CFC, 4'b0000, 32'h5);
        issue(1'b0, DATA_A, 4'b1000, 32'h0);
        expect_pci("R7 be1000 legal", 4'hA, 32'h0000_8004, 4'b1000, 32'h0);
        issue(1'b0, DATA_A, 4'b0011, 32'h0);
        expect_pci("R7 be0011 legal", 4'hA, 32'h0000_8004, 4'b0011, 32'h0);
    endtask

    task automatic t_plain_io;
        issue(1'b1, 32'h8000_0100, 4'b0001, 32'hA5A5_5A5A);
        expect_pci("R8 R10 io write", 4'h3, 32'h0000_0100, 4'b0001, 32'hA5A5_5A5A);
        issue(1'b0, 32'h8000_FFFC, 4'hF, 32'h0);
        expect_pci("R8 io read top", 4'h2, 32'h0000_FFFC, 4'hF, 32'h0);
    endtask

    task automatic t_outside;
        issue(1'b0, 32'h9000_0CFC, 4'hF, 32'h0);
        chk("R9 outside read no pci", {31'b0, pci_req_valid}, 32'd0);
        chk("R9 outside read no rsp", {31'b0, rsp_valid}, 32'd0);
        issue(1'b1, 32'h0000_0CF8, 4'hF, 32'hFFFF_FFFF);
        chk("R9 outside write no pci", {31'b0, pci_req_valid}, 32'd0);
        read_setup("R9 setup unchanged", cfg_word(1'b1, 8'd0, 4, 0, 1));
        @(negedge clk);
        chk("R8 idle after request", {31'b0, pci_req_valid}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_be = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_setup_slot();
        t_setup_narrow();
        t_cfg_cycles();
        t_invalid_setup();
        t_widths();
        t_plain_io();
        t_outside();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule